// File: doc/BRIEF.md
# Single-Cycle Integer Core Control Decoder

This block is the combinational control unit of a single-cycle 32-bit integer processor. It sees only a short key taken from the fetched instruction: the 5-bit major opcode field (bits 6:2), the 3-bit function field (bits 14:12) and the alternate-operation bit (bit 30). It also sees the two result flags from the branch comparator. From these inputs it drives every select and enable line in the datapath: the next-PC source, the immediate format, the comparator signedness, both ALU operand sources, the ALU operation, the memory direction, the register write enable and the writeback source.

The eleven key bits are concatenated into a lookup address as {bit 30, bits 14:12, bits 6:2, equal flag, less flag}. That address indexes a 2048-entry table of 15-bit control words. The table is computed at elaboration by one package function, so adding or correcting an instruction means editing that function only. Because both comparator flags are part of the address, the branch decision comes out of the same lookup as every other field. Any key that matches no supported instruction returns a safe word that changes no architectural state.

The block has no clock and no state: outputs follow inputs within the same cycle.

Top module: `rv_ctrl_decoder`

## Requirements
- R1: For any key whose opcode is not the branch opcode (11000), the control word is identical for all four combinations of `cmp_equal` and `cmp_less`.
- R2: Register-register keys (opcode 01100) produce: immediate format 0, operand A from register, operand B from register, register write 1, writeback from ALU, sequential PC and memory read.
  - The ALU code follows the function field: 000 add=0 (sub=1 when bit 30 is set), 001 sll=2, 010 slt=3, 011 sltu=4, 100 xor=5, 101 srl=6 (sra=7 when bit 30 is set), 110 or=8, 111 and=9.
  - Bit 30 set with any other function field is illegal.
- R3: Register-immediate keys (opcode 00100) produce the same ALU codes as R2 with operand B from the immediate and immediate format I=0.
  - Bit 30 is ignored, except that it selects sra over srl for function field 101.
  - Bit 30 set with function field 001 is illegal.
- R4: The word load (opcode 00000, function 010) produces: format I, operand A from register, operand B from immediate, ALU add, memory read, register write 1, writeback from memory=0.
- R5: The word store (opcode 01000, function 010) produces: format S=1, operand A from register, operand B from immediate, ALU add, memory write=1, register write 0.
- R6: For branch-if-equal (opcode 11000, function 000), the PC source is the ALU target=1 when the equal flag is 1, and PC+4=0 otherwise. Branch-if-not-equal (function 001) does the opposite.
  - All branches use format B=2, operand A=PC (1), operand B=immediate (1), ALU add, register write 0 and memory read.
- R7: Branch-if-less (function 100 signed, 110 unsigned) takes the ALU target when the less flag is 1. Branch-if-greater-or-equal (function 101 signed, 111 unsigned) takes it when the less flag is 0.
  - The comparator-unsigned output is 1 exactly for the unsigned forms.
  - Function fields 010 and 011 under the branch opcode are illegal.
- R8: The PC-relative jump (opcode 11011, any other key bits) produces: format J=4, operand A=PC, operand B=immediate, ALU add, PC source ALU, register write 1, writeback PC+4=2.
- R9: The register-indirect jump (opcode 11001, function 000) produces: format I, operand A=register, operand B=immediate, ALU add, PC source ALU, register write 1, writeback PC+4. Other function fields are illegal.
- R10: Both upper-immediate keys produce format U=3, operand B=immediate, register write 1, writeback ALU and sequential PC.
  - Load-upper (opcode 01101) uses ALU pass-B=10 with operand A=register (0).
  - Add-upper-to-PC (opcode 00101) uses ALU add with operand A=PC.
- R11: Every other key produces the safe word. Its fields are: PC+4, format 0, comparator signed, operand A register, operand B register, ALU add, memory read, register write 0, writeback ALU.
- R12: Field codes: PC source 0=PC+4 and 1=ALU; operand A 0=register and 1=PC; operand B 0=register and 1=immediate; memory 0=read and 1=write; writeback 0=memory, 1=ALU and 2=PC+4. Writeback code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| key_alt | input | 1 | Instruction bit 30 |
| key_funct3 | input | 3 | Instruction bits 14:12 |
| key_opcode | input | 5 | Instruction bits 6:2 |
| cmp_equal | input | 1 | Branch comparator: operands equal |
| cmp_less | input | 1 | Branch comparator: A less than B |
| next_pc_alu | output | 1 | PC source: 0 = PC+4, 1 = ALU result |
| imm_fmt | output | 3 | Immediate format: I=0, S=1, B=2, U=3, J=4 |
| cmp_unsigned | output | 1 | Comparator performs unsigned compare |
| opa_pc | output | 1 | ALU operand A: 0 = register, 1 = PC |
| opb_imm | output | 1 | ALU operand B: 0 = register, 1 = immediate |
| alu_op | output | 4 | ALU operation code |
| mem_write | output | 1 | Data memory: 0 = read, 1 = write |
| rd_write | output | 1 | Register file write enable |
| wb_src | output | 2 | Writeback: 0 = memory, 1 = ALU, 2 = PC+4 |

## Verification
The hardest cases to reach are the keys that sit inside a legal opcode but carry an illegal function field or alternate bit: a branch with function 010, a shift-left-immediate with bit 30 set, a register-indirect jump with a nonzero function field. These must come out as the safe word under every flag combination. A random instruction stream rarely hits them, so the stimulus sweeps all 2048 lookup addresses in order, with random values in the instruction bits outside the key. Every table entry is therefore compared against the reference model. Because consecutive addresses differ only in the two flags, the same sweep also shows directly that non-branch words ignore the flags.

// File: rtl/rv_ctrl_pkg.sv
package rv_ctrl_pkg;

    localparam int KEY_ADDR_W = 11;
    localparam int CTRL_W     = 15;

    // Major opcode values (instruction bits 6:2)
    localparam logic [4:0] OPC_LOAD   = 5'b00000;
    localparam logic [4:0] OPC_OPIMM  = 5'b00100;
    localparam logic [4:0] OPC_AUIPC  = 5'b00101;
    localparam logic [4:0] OPC_STORE  = 5'b01000;
    localparam logic [4:0] OPC_OP     = 5'b01100;
    localparam logic [4:0] OPC_LUI    = 5'b01101;
    localparam logic [4:0] OPC_BRANCH = 5'b11000;
    localparam logic [4:0] OPC_JALR   = 5'b11001;
    localparam logic [4:0] OPC_JAL    = 5'b11011;

    typedef enum logic {PC_SEQ = 1'b0, PC_ALU = 1'b1} pc_src_e;
    typedef enum logic [2:0] {
        IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4
    } imm_fmt_e;
    typedef enum logic {A_REG = 1'b0, A_PC = 1'b1} opa_src_e;
    typedef enum logic {B_REG = 1'b0, B_IMM = 1'b1} opb_src_e;
    typedef enum logic {MEM_RD = 1'b0, MEM_WR = 1'b1} mem_dir_e;
    typedef enum logic [1:0] {WB_MEM = 2'd0, WB_ALU = 2'd1, WB_LINK = 2'd2} wb_src_e;
    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
        ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
        ALU_OR   = 4'd8, ALU_AND = 4'd9, ALU_PASSB = 4'd10
    } alu_op_e;

    typedef struct packed {
        pc_src_e  pc_src;
        imm_fmt_e imm_fmt;
        logic     cmp_uns;
        opa_src_e opa;
        opb_src_e opb;
        alu_op_e  alu;
        mem_dir_e mem_dir;
        logic     rd_we;
        wb_src_e  wb;
    } ctrl_word_t;

    // Word that leaves all architectural state untouched
    function automatic ctrl_word_t safe_word();
        ctrl_word_t w;
        w.pc_src  = PC_SEQ;
        w.imm_fmt = IMM_I;
        w.cmp_uns = 1'b0;
        w.opa     = A_REG;
        w.opb     = B_REG;
        w.alu     = ALU_ADD;
        w.mem_dir = MEM_RD;
        w.rd_we   = 1'b0;
        w.wb      = WB_ALU;
        return w;
    endfunction

    // ALU code from function field; alt picks sub/sra
    function automatic alu_op_e alu_from_funct(input logic [2:0] f3, input logic alt);
        unique case (f3)
            3'b000:  return alt ? ALU_SUB : ALU_ADD;
            3'b001:  return ALU_SLL;
            3'b010:  return ALU_SLT;
            3'b011:  return ALU_SLTU;
            3'b100:  return ALU_XOR;
            3'b101:  return alt ? ALU_SRA : ALU_SRL;
            3'b110:  return ALU_OR;
            default: return ALU_AND;
        endcase
    endfunction

    // One table entry; address = {alt, funct3, opcode, eq, lt}
    function automatic ctrl_word_t decode_entry(input logic [KEY_ADDR_W-1:0] a);
        ctrl_word_t w;
        logic       alt;
        logic [2:0] f3;
        logic [4:0] opc;
        logic       eq;
        logic       lt;
        logic       take;
        alt  = a[10];
        f3   = a[9:7];
        opc  = a[6:2];
        eq   = a[1];
        lt   = a[0];
        take = 1'b0;
        w    = safe_word();
        unique case (opc)
            OPC_OP: begin
                if (!alt || f3 == 3'b000 || f3 == 3'b101) begin
                    w.alu   = alu_from_funct(f3, alt);
                    w.rd_we = 1'b1;
                end
            end
            OPC_OPIMM: begin
                if (!(alt && f3 == 3'b001)) begin
                    w.alu   = alu_from_funct(f3, alt && f3 == 3'b101);
                    w.opb   = B_IMM;
                    w.rd_we = 1'b1;
                end
            end
            OPC_LOAD: begin
                if (f3 == 3'b010) begin
                    w.opb   = B_IMM;
                    w.rd_we = 1'b1;
                    w.wb    = WB_MEM;
                end
            end
            OPC_STORE: begin
                if (f3 == 3'b010) begin
                    w.imm_fmt = IMM_S;
                    w.opb     = B_IMM;
                    w.mem_dir = MEM_WR;
                end
            end
            OPC_BRANCH: begin
                if (f3[2:1] != 2'b01) begin
                    unique case (f3)
                        3'b000:  take = eq;
                        3'b001:  take = !eq;
                        3'b100,
                        3'b110:  take = lt;
                        default: take = !lt;
                    endcase
                    w.imm_fmt = IMM_B;
                    w.cmp_uns = f3[1];
                    w.opa     = A_PC;
                    w.opb     = B_IMM;
                    w.pc_src  = take ? PC_ALU : PC_SEQ;
                end
            end
            OPC_JALR: begin
                if (f3 == 3'b000) begin
                    w.opb    = B_IMM;
                    w.pc_src = PC_ALU;
                    w.rd_we  = 1'b1;
                    w.wb     = WB_LINK;
                end
            end
            OPC_JAL: begin
                w.imm_fmt = IMM_J;
                w.opa     = A_PC;
                w.opb     = B_IMM;
                w.pc_src  = PC_ALU;
                w.rd_we   = 1'b1;
                w.wb      = WB_LINK;
            end
            OPC_LUI: begin
                w.imm_fmt = IMM_U;
                w.opb     = B_IMM;
                w.alu     = ALU_PASSB;
                w.rd_we   = 1'b1;
            end
            OPC_AUIPC: begin
                w.imm_fmt = IMM_U;
                w.opa     = A_PC;
                w.opb     = B_IMM;
                w.rd_we   = 1'b1;
            end
            default: w = safe_word();
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rv_ctrl_key_pack.sv
module rv_ctrl_key_pack
    import rv_ctrl_pkg::*;
#(
    parameter int ADDR_W = KEY_ADDR_W
) (
    input  logic              alt,
    input  logic [2:0]        funct3,
    input  logic [4:0]        opcode,
    input  logic              flag_eq,
    input  logic              flag_lt,
    output logic [ADDR_W-1:0] addr
);
    // Bit order is fixed: the table function decodes it
    assign addr = {alt, funct3, opcode, flag_eq, flag_lt};
endmodule

// File: rtl/rv_ctrl_rom.sv
module rv_ctrl_rom
    import rv_ctrl_pkg::*;
#(
    parameter int ADDR_W = KEY_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output ctrl_word_t        word
);
    localparam int DEPTH = 1 << ADDR_W;

    ctrl_word_t entries [DEPTH];

    // Each entry is a constant computed at elaboration
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign entries[g] = decode_entry(KEY_ADDR_W'(g));
    end

    assign word = entries[addr];
endmodule

// File: rtl/rv_ctrl_split.sv
module rv_ctrl_split
    import rv_ctrl_pkg::*;
(
    input  ctrl_word_t word,
    output logic       pc_alu,
    output logic [2:0] imm_fmt,
    output logic       cmp_uns,
    output logic       opa_pc,
    output logic       opb_imm,
    output logic [3:0] alu_op,
    output logic       mem_wr,
    output logic       rd_we,
    output logic [1:0] wb_src
);
    assign pc_alu  = word.pc_src;
    assign imm_fmt = word.imm_fmt;
    assign cmp_uns = word.cmp_uns;
    assign opa_pc  = word.opa;
    assign opb_imm = word.opb;
    assign alu_op  = word.alu;
    assign mem_wr  = word.mem_dir;
    assign rd_we   = word.rd_we;
    assign wb_src  = word.wb;
endmodule

// File: rtl/rv_ctrl_decoder.sv
module rv_ctrl_decoder
    import rv_ctrl_pkg::*;
(
    input  logic       key_alt,
    input  logic [2:0] key_funct3,
    input  logic [4:0] key_opcode,
    input  logic       cmp_equal,
    input  logic       cmp_less,
    output logic       next_pc_alu,
    output logic [2:0] imm_fmt,
    output logic       cmp_unsigned,
    output logic       opa_pc,
    output logic       opb_imm,
    output logic [3:0] alu_op,
    output logic       mem_write,
    output logic       rd_write,
    output logic [1:0] wb_src
);
    logic [KEY_ADDR_W-1:0] lookup_addr;
    ctrl_word_t            lookup_word;

    rv_ctrl_key_pack #(.ADDR_W(KEY_ADDR_W)) u_pack (
        .alt     (key_alt),
        .funct3  (key_funct3),
        .opcode  (key_opcode),
        .flag_eq (cmp_equal),
        .flag_lt (cmp_less),
        .addr    (lookup_addr)
    );

    rv_ctrl_rom #(.ADDR_W(KEY_ADDR_W)) u_rom (
        .addr (lookup_addr),
        .word (lookup_word)
    );

    rv_ctrl_split u_split (
        .word    (lookup_word),
        .pc_alu  (next_pc_alu),
        .imm_fmt (imm_fmt),
        .cmp_uns (cmp_unsigned),
        .opa_pc  (opa_pc),
        .opb_imm (opb_imm),
        .alu_op  (alu_op),
        .mem_wr  (mem_write),
        .rd_we   (rd_write),
        .wb_src  (wb_src)
    );

    // Output checks against the key that produced them
    always_comb begin
        if (!$isunknown({key_alt, key_funct3, key_opcode, cmp_equal, cmp_less})) begin
            AST_LINK_WRITES: assert (wb_src != 2'd2 || (rd_write && next_pc_alu)) else $error("link writeback without jump"); // R8
            AST_STORE_NO_RD: assert (!mem_write || !rd_write) else $error("store also writes register"); // R5
            AST_BRANCH_NO_RD: assert (lookup_addr[6:2] != OPC_BRANCH || (!rd_write && !mem_write)) else $error("branch changes state"); // R6
            AST_UNS_ONLY_BRANCH: assert (!cmp_unsigned || lookup_addr[6:2] == OPC_BRANCH) else $error("unsigned compare off branch"); // R7
            AST_WB_CODE_LEGAL: assert (wb_src != 2'd3) else $error("reserved writeback code"); // R12
            AST_REDIRECT_ONLY_CTRL: assert (!next_pc_alu || key_opcode == OPC_BRANCH || key_opcode == OPC_JAL || key_opcode == OPC_JALR) else $error("redirect from non-control key"); // R11
        end
    end
endmodule

// File: tb/rv_ctrl_decoder_test.sv
module rv_ctrl_decoder_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       key_alt;
    logic [2:0] key_funct3;
    logic [4:0] key_opcode;
    logic       cmp_equal, cmp_less;
    logic       next_pc_alu, cmp_unsigned, opa_pc, opb_imm, mem_write, rd_write;
    logic [2:0] imm_fmt;
    logic [3:0] alu_op;
    logic [1:0] wb_src;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    rv_ctrl_decoder uut (
        .key_alt(key_alt), .key_funct3(key_funct3), .key_opcode(key_opcode),
        .cmp_equal(cmp_equal), .cmp_less(cmp_less),
        .next_pc_alu(next_pc_alu), .imm_fmt(imm_fmt), .cmp_unsigned(cmp_unsigned),
        .opa_pc(opa_pc), .opb_imm(opb_imm), .alu_op(alu_op),
        .mem_write(mem_write), .rd_write(rd_write), .wb_src(wb_src)
    );

    function automatic logic [14:0] pack(int pc, int im, int un, int a, int b, int alu, int mw, int rw, int wb);
        return {pc[0], im[2:0], un[0], a[0], b[0], alu[3:0], mw[0], rw[0], wb[1:0]};
    endfunction

    function automatic int alu_code(logic [2:0] f3, logic alt);
        case (f3)
            3'd0: return alt ? 1 : 0;
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 4;
            3'd4: return 5;
            3'd5: return alt ? 7 : 6;
            3'd6: return 8;
            default: return 9;
        endcase
    endfunction

    // Behavioural reference built from the requirement text
    task automatic reference(input logic [31:0] ins, input logic eq, input logic lt,
                             output logic [14:0] w, output string tag);
        logic [4:0] opc = ins[6:2];
        logic [2:0] f3 = ins[14:12];
        logic alt = ins[30];
        bit tk;
        w = pack(0, 0, 0, 0, 0, 0, 0, 0, 1);
        tag = "R11";
        if (opc == 5'b01100) begin
            if (!alt || f3 == 0 || f3 == 5) begin
                w = pack(0, 0, 0, 0, 0, alu_code(f3, alt), 0, 1, 1); tag = "R2";
            end
        end else if (opc == 5'b00100) begin
            if (!(alt && f3 == 1)) begin
                w = pack(0, 0, 0, 0, 1, alu_code(f3, (f3 == 5) ? alt : 1'b0), 0, 1, 1); tag = "R3";
            end
        end else if (opc == 5'b00000 && f3 == 2) begin
            w = pack(0, 0, 0, 0, 1, 0, 0, 1, 0); tag = "R4";
        end else if (opc == 5'b01000 && f3 == 2) begin
            w = pack(0, 1, 0, 0, 1, 0, 1, 0, 1); tag = "R5";
        end else if (opc == 5'b11000 && f3 != 2 && f3 != 3) begin
            case (f3)
                3'd0: tk = eq;
                3'd1: tk = !eq;
                3'd4, 3'd6: tk = lt;
                default: tk = !lt;
            endcase
            w = pack(tk, 2, (f3 >= 6) ? 1 : 0, 1, 1, 0, 0, 0, 1);
            tag = (f3 < 2) ? "R6" : "R7";
        end else if (opc == 5'b11011) begin
            w = pack(1, 4, 0, 1, 1, 0, 0, 1, 2); tag = "R8";
        end else if (opc == 5'b11001 && f3 == 0) begin
            w = pack(1, 0, 0, 0, 1, 0, 0, 1, 2); tag = "R9";
        end else if (opc == 5'b01101) begin
            w = pack(0, 3, 0, 0, 1, 10, 0, 1, 1); tag = "R10";
        end else if (opc == 5'b00101) begin
            w = pack(0, 3, 0, 1, 1, 0, 0, 1, 1); tag = "R10";
        end
    endtask

    function automatic logic [14:0] observed();
        return {next_pc_alu, imm_fmt, cmp_unsigned, opa_pc, opb_imm, alu_op, mem_write, rd_write, wb_src};
    endfunction

    task automatic apply(input logic [31:0] ins, input logic eq, input logic lt);
        @(negedge clk);
        key_alt = ins[30]; key_funct3 = ins[14:12]; key_opcode = ins[6:2];
        cmp_equal = eq; cmp_less = lt;
        @(posedge clk);
        #1;
    endtask

    task automatic compare(input logic [31:0] ins, input logic eq, input logic lt);
        logic [14:0] exp;
        string tag;
        reference(ins, eq, lt, exp, tag);
        checks++;
        if (observed() !== exp) begin
            errors++;
            $display("FAIL %s inst=%h eq=%0b lt=%0b actual=%h expected=%h", tag, ins, eq, lt, observed(), exp);
        end
    endtask

    initial begin
        logic [14:0] base_word;
        logic [31:0] ins;
        key_alt = 0; key_funct3 = 0; key_opcode = 0; cmp_equal = 0; cmp_less = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R12 / R11: all-zero key after reset is the safe word
        apply(32'h0, 1'b0, 1'b0);
        checks++;
        if (observed() !== 15'h0001) begin
            errors++;
            $display("FAIL R12 zero key actual=%h expected=%h", observed(), 15'h0001);
        end

        // Exhaustive sweep over all 2048 lookup addresses
        for (int a = 0; a < 2048; a++) begin
            logic [10:0] ad = 11'(a);
            ins = $urandom;
            ins[30] = ad[10]; ins[14:12] = ad[9:7]; ins[6:2] = ad[6:2]; ins[1:0] = 2'b11;
            apply(ins, ad[1], ad[0]);
            compare(ins, ad[1], ad[0]);
            // R1: flags must not move non-branch words
            if (ad[1:0] == 2'b00) base_word = observed();
            else if (ad[6:2] != 5'b11000) begin
                checks++;
                if (observed() !== base_word) begin
                    errors++;
                    $display("FAIL R1 addr=%h actual=%h expected=%h", ad, observed(), base_word);
                end
            end
        end

        // Directed branch flag pairs (R6, R7)
        for (int f = 0; f < 8; f++) begin
            for (int fl = 0; fl < 4; fl++) begin
                ins = 32'h0000_0063 | (32'(f) << 12);
                apply(ins, fl[1], fl[0]);
                compare(ins, fl[1], fl[0]);
            end
        end

        // Biased random stream over the legal opcodes
        for (int n = 0; n < 1500; n++) begin
            logic [4:0] pick [10] = '{5'b00000, 5'b00100, 5'b00101, 5'b01000, 5'b01100,
                                     5'b01101, 5'b11000, 5'b11001, 5'b11011, 5'b11111};
            logic e = 1'($urandom);
            logic l = 1'($urandom);
            ins = $urandom;
            ins[6:2] = pick[$urandom_range(0, 9)];
            apply(ins, e, l);
            compare(ins, e, l);
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule